// File: doc/BRIEF.md
# I2C Bus Hang Guard

This block watches the two synchronised lines of an I2C bus for silence. Each edge on either line restarts an inactivity timer. If the timer runs out while the data line rests high, the block reports that the bus is free. If the timer runs out while the data line is held low, the block treats the bus as hung. In that case it clocks the bus out of the hang by driving the clock line low in open-drain fashion, for a fixed number of pulses.

Time is counted in units produced by a clock prescaler. With `TICK_DIV = 10` at 250 MHz, one unit is 40 ns. The timeout has two settings, a long one (about 1 s by default) and a short one (about 50 us by default), and one input selects between them. A second input switches the whole guard off. The width of each pulse comes from two 8-bit count inputs, one for the low phase and one for the high phase, both in prescaler units. The register values usually driven onto them are 0xA5 for the low phase and 0xA1 for the high phase. Protocol decoding is not part of this block.

Top module: `i2c_hang_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_free`, `recovering` and `scl_drive_low` are all 0.
- R2: Outside recovery, any change on `scl_in` or `sda_in` clears `bus_free` on the next clock edge and restarts the inactivity timeout from zero.
- R3: With `wd_fast = 0` and `sda_in` high, `bus_free` becomes 1 on the edge that lies `LONG_LIMIT*TICK_DIV` cycles after the edge that sampled the last line change.
- R4: With `wd_fast = 1` and `sda_in` high, the same rule holds with `SHORT_LIMIT*TICK_DIV` cycles.
- R5: If the timeout ends while `sda_in` is low, `recovering` rises on that edge and `bus_free` stays 0. `bus_free` and `recovering` are never 1 together.
- R6: Each recovery pulse holds `scl_drive_low` at 1 for `scl_lo_units*TICK_DIV` cycles and then at 0 for `scl_hi_units*TICK_DIV` cycles, for widths of 1 or more. The first low phase starts together with `recovering`.
- R7: If `sda_in` stays low, a recovery issues exactly `PULSES` (9) pulses. `recovering` falls at the end of the last high phase.
- R8: If `sda_in` is high when a pulse's high phase ends, recovery stops after that pulse.
- R9: When a recovery finishes, the timer restarts from zero. A further silent interval of the selected length then either declares the bus free or starts a new recovery.
- R10: While `wd_disable` is 1, all three outputs are 0 from the next edge onward. Any recovery in progress is dropped, and no timeout is counted.
- R11: Line edges during a recovery, including those caused by its own clock pulses, neither stop it nor restart it.
- R12: `scl_drive_low` is only ever 1 while `recovering` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronised clock line level |
| sda_in | input | 1 | Synchronised data line level |
| wd_disable | input | 1 | 1 switches the guard off |
| wd_fast | input | 1 | 1 selects the short timeout |
| scl_lo_units | input | WIDTH_W | Low-phase width of a recovery pulse, in prescaler units |
| scl_hi_units | input | WIDTH_W | High-phase width of a recovery pulse, in prescaler units |
| bus_free | output | 1 | Bus judged idle |
| recovering | output | 1 | Recovery sequence in progress |
| scl_drive_low | output | 1 | 1 pulls the clock line low; 0 releases it |

## Verification
The bench measures the exact cycle on which each timeout fires, for both settings. A design off by one prescaler period, or one that does not restart the prescaler on an edge, would miss that cycle. It counts every low and high phase of a full recovery and glitches the data line in the middle of a pulse. A sequencer that sampled the data line at the wrong moment would then stop early, and a pulse counter off by one would give eight or ten pulses. It releases the data line partway through a recovery to confirm that the sequence exits after that pulse and that the timer rearms. It also aborts a recovery through the disable input, where a design that left the clock line pulled low would stall the bus.

// File: rtl/hang_guard_pkg.sv
package hang_guard_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_LOW  = 2'd1,
    RS_HIGH = 2'd2
  } rec_state_e;
endpackage

// File: rtl/guard_tick.sv
// Unit-time prescaler; restart realigns the unit grid to the current cycle.
module guard_tick #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    tick = (pre_q == LAST) && !restart;
    if (restart || (pre_q == LAST)) pre_d = '0;
    else                            pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/guard_idle_timer.sv
// Inactivity counter with two selectable limits, in unit ticks.
module guard_idle_timer #(
  parameter int unsigned LONG_LIMIT  = 25_000_000,
  parameter int unsigned SHORT_LIMIT = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clear,
  input  logic tick,
  input  logic fast,
  output logic timeout
);
  localparam int unsigned CW = $clog2(LONG_LIMIT + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LIMIT - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  always_comb begin
    at_end  = cnt_q >= (fast ? SHORT_LAST : LONG_LAST);
    timeout = en && !clear && tick && at_end;
    cnt_d   = cnt_q;
    if (clear || !en) cnt_d = '0;
    else if (tick)    cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/guard_pulse_seq.sv
// Recovery pulse train: low phase, then released phase, repeated.
module guard_pulse_seq
  import hang_guard_pkg::*;
#(
  parameter int unsigned PULSES  = 9,
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               tick,
  input  logic               sda_in,
  input  logic [WIDTH_W-1:0] lo_units,
  input  logic [WIDTH_W-1:0] hi_units,
  output logic               recovering,
  output logic               scl_low
);
  localparam int unsigned NW = $clog2(PULSES + 1);
  localparam logic [NW-1:0] N_LAST = NW'(PULSES - 1);

  rec_state_e         st_q, st_d;
  logic [WIDTH_W-1:0] ph_q, ph_d;
  logic [NW-1:0]      n_q, n_d;
  logic [WIDTH_W:0]   ph_next, width;
  logic               phase_last;

  always_comb begin
    width      = {1'b0, (st_q == RS_LOW) ? lo_units : hi_units};
    ph_next    = {1'b0, ph_q} + (WIDTH_W + 1)'(1);
    phase_last = ph_next >= width;
    st_d = st_q;
    ph_d = ph_q;
    n_d  = n_q;
    case (st_q)
      RS_IDLE: if (start) begin
        st_d = RS_LOW;
        ph_d = '0;
        n_d  = '0;
      end
      RS_LOW: if (tick) begin
        if (phase_last) begin
          st_d = RS_HIGH;
          ph_d = '0;
        end else ph_d = ph_q + 1'b1;
      end
      RS_HIGH: if (tick) begin
        if (phase_last) begin
          n_d  = n_q + 1'b1;
          ph_d = '0;
          st_d = (sda_in || (n_q == N_LAST)) ? RS_IDLE : RS_LOW;
        end else ph_d = ph_q + 1'b1;
      end
      default: st_d = RS_IDLE;
    endcase
    if (abort) begin
      st_d = RS_IDLE;
      ph_d = '0;
      n_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_IDLE;
      ph_q <= '0;
      n_q  <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      n_q  <= n_d;
    end
  end

  assign recovering = (st_q != RS_IDLE);
  assign scl_low    = (st_q == RS_LOW);
endmodule

// File: rtl/i2c_hang_guard.sv
module i2c_hang_guard #(
  parameter int unsigned TICK_DIV    = 10,
  parameter int unsigned LONG_LIMIT  = 25_000_000,
  parameter int unsigned SHORT_LIMIT = 1250,
  parameter int unsigned PULSES      = 9,
  parameter int unsigned WIDTH_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               wd_disable,
  input  logic               wd_fast,
  input  logic [WIDTH_W-1:0] scl_lo_units,
  input  logic [WIDTH_W-1:0] scl_hi_units,
  output logic               bus_free,
  output logic               recovering,
  output logic               scl_drive_low
);
  logic prev_scl_q, prev_sda_q;
  logic bus_free_q, bus_free_d;
  logic act, fresh, watch, tick, timeout, rec, scl_low;

  always_comb begin
    act   = (scl_in ^ prev_scl_q) | (sda_in ^ prev_sda_q);
    fresh = act && !rec;
    watch = !wd_disable && !rec;
    bus_free_d = bus_free_q;
    if (wd_disable || fresh)   bus_free_d = 1'b0;
    else if (timeout && sda_in) bus_free_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
      bus_free_q <= 1'b0;
    end else begin
      prev_scl_q <= scl_in;
      prev_sda_q <= sda_in;
      bus_free_q <= bus_free_d;
    end
  end

  guard_tick #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wd_disable | fresh),
    .tick    (tick)
  );

  guard_idle_timer #(.LONG_LIMIT(LONG_LIMIT), .SHORT_LIMIT(SHORT_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (watch),
    .clear   (fresh),
    .tick    (tick),
    .fast    (wd_fast),
    .timeout (timeout)
  );

  guard_pulse_seq #(.PULSES(PULSES), .WIDTH_W(WIDTH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (timeout && !sda_in),
    .abort      (wd_disable),
    .tick       (tick),
    .sda_in     (sda_in),
    .lo_units   (scl_lo_units),
    .hi_units   (scl_hi_units),
    .recovering (rec),
    .scl_low    (scl_low)
  );

  assign bus_free      = bus_free_q;
  assign recovering    = rec;
  assign scl_drive_low = scl_low;
endmodule

// File: rtl/hang_guard_chk.sv
module hang_guard_chk #(
  parameter int unsigned PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_in,
  input logic wd_disable,
  input logic bus_free,
  input logic recovering,
  input logic scl_drive_low
);
  logic [7:0] seen_q;
  logic       low_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= '0;
      low_prev_q <= 1'b0;
    end else begin
      low_prev_q <= scl_drive_low;
      if (!recovering)                      seen_q <= '0;
      else if (scl_drive_low && !low_prev_q) seen_q <= seen_q + 1'b1;
    end
  end

  // R12
  drive_only_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> recovering);

  // R10
  disable_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_disable |=> (!bus_free && !recovering && !scl_drive_low));

  // R5
  free_recover_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_free && recovering));

  // R5
  recover_needs_low_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> !$past(sda_in));

  // R3
  free_needs_high_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(sda_in));

  // R2
  edge_clears_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!recovering && ((sda_in != $past(sda_in)) || (scl_in != $past(scl_in)))) |=> !bus_free);

  // R7
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= 8'(PULSES));

  // R8
  exit_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(recovering) && !$past(wd_disable)) |-> !$past(scl_drive_low));
endmodule

bind i2c_hang_guard hang_guard_chk #(.PULSES(PULSES)) u_hang_guard_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_in        (scl_in),
  .sda_in        (sda_in),
  .wd_disable    (wd_disable),
  .bus_free      (bus_free),
  .recovering    (recovering),
  .scl_drive_low (scl_drive_low)
);

// File: tb/tb_i2c_hang_guard.sv
`timescale 1ns/1ps
module tb_i2c_hang_guard;
  localparam int DIV = 2;
  localparam int LNG = 40;
  localparam int SHT = 10;
  localparam int LO  = 3;
  localparam int HI  = 2;
  localparam int NP  = 9;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, wd_disable, wd_fast;
  logic [7:0] lo_u, hi_u;
  logic scl_in, sda_in, bus_free, recovering, scl_drive_low;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_in = scl_m & ~scl_drive_low;
  assign sda_in = sda_m;

  i2c_hang_guard #(.TICK_DIV(DIV), .LONG_LIMIT(LNG), .SHORT_LIMIT(SHT), .PULSES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .wd_disable(wd_disable), .wd_fast(wd_fast),
    .scl_lo_units(lo_u), .scl_hi_units(hi_u),
    .bus_free(bus_free), .recovering(recovering), .scl_drive_low(scl_drive_low)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_for(input bit want_rec, output int n);
    n = 0;
    for (int k = 1; k <= 600; k++) begin
      @(posedge clk); #1;
      if (want_rec ? recovering : bus_free) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic pulse_scl();
    @(negedge clk) scl_m = 1'b0;
    @(negedge clk) scl_m = 1'b1;
  endtask

  // Called on the first sample showing recovering = 1.
  task automatic watch_recovery(input int release_at, input int glitch_at,
                                output int pulses, output int bad, output int cycles);
    int lo_run, hi_run;
    logic was_low;
    pulses = 1; bad = 0; cycles = 1; lo_run = 1; hi_run = 0; was_low = 1'b1;
    if (!scl_drive_low) bad++;
    for (int k = 0; k < 2000; k++) begin
      if (was_low && pulses == release_at && lo_run == 1) sda_m = 1'b1;
      if (was_low && pulses == glitch_at) begin
        if (lo_run == 1) sda_m = 1'b1;
        else if (lo_run == 2) sda_m = 1'b0;
      end
      @(posedge clk); #1;
      if (!recovering) begin
        if (hi_run != HI*DIV) bad++;
        break;
      end
      cycles++;
      if (scl_drive_low) begin
        if (!was_low) begin
          if (hi_run != HI*DIV) bad++;
          pulses++;
          lo_run = 0;
        end
        lo_run++;
      end else begin
        if (was_low) begin
          if (lo_run != LO*DIV) bad++;
          hi_run = 0;
        end
        hi_run++;
      end
      was_low = scl_drive_low;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wd_disable = 1'b0; wd_fast = 1'b1;
    lo_u = 8'(LO); hi_u = 8'(HI);
    repeat (5) @(posedge clk);
    #1;
    check("R1 reset outputs", {29'd0, bus_free, recovering, scl_drive_low}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle outputs", {29'd0, bus_free, recovering, scl_drive_low}, 0);
  endtask

  task automatic t_short_free();
    int n;
    wd_fast = 1'b1;
    pulse_scl();
    wait_for(1'b0, n);
    check("R4 short timeout cycle", n, SHT*DIV + 1);
  endtask

  task automatic t_long_free();
    int n;
    wd_fast = 1'b0;
    pulse_scl();
    wait_for(1'b0, n);
    check("R3 long timeout cycle", n, LNG*DIV + 1);
  endtask

  task automatic t_activity();
    int n, seen;
    wd_fast = 1'b1;
    @(negedge clk) sda_m = 1'b0;
    @(posedge clk); #1;
    check("R2 edge clears bus_free", bus_free, 0);
    @(negedge clk) sda_m = 1'b1;
    seen = 0;
    repeat (11) begin
      @(negedge clk);
      if (bus_free) seen++;
    end
    check("R2 no free before restart", seen, 0);
    pulse_scl();
    wait_for(1'b0, n);
    check("R2 timer restarted by scl edge", n, SHT*DIV + 1);
  endtask

  task automatic t_full_recovery();
    int n, p, bad, cyc;
    wd_fast = 1'b1;
    @(negedge clk) sda_m = 1'b0;
    wait_for(1'b1, n);
    check("R5 recovery start cycle", n, SHT*DIV + 1);
    check("R5 bus_free low at start", bus_free, 0);
    watch_recovery(0, 2, p, bad, cyc);
    check("R7 pulse count", p, NP);
    check("R6 phase widths", bad, 0);
    check("R11 glitch ignored, length", cyc, NP*(LO+HI)*DIV);
    wait_for(1'b1, n);
    check("R9 rearm into second recovery", n, SHT*DIV);
  endtask

  task automatic t_disable();
    int n, seen;
    repeat (3) @(negedge clk);
    wd_disable = 1'b1;
    @(posedge clk); #1;
    check("R10 abort outputs", {29'd0, bus_free, recovering, scl_drive_low}, 0);
    seen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (k == 10) sda_m = 1'b1;
      if (k == 30) sda_m = 1'b0;
      if (bus_free || recovering || scl_drive_low) seen++;
    end
    check("R10 quiet while disabled", seen, 0);
    @(negedge clk) wd_disable = 1'b0;
    wait_for(1'b1, n);
    check("R10 counting resumes after enable", n, SHT*DIV);
  endtask

  task automatic t_early_exit();
    int n, p, bad, cyc;
    watch_recovery(3, 0, p, bad, cyc);
    check("R8 early exit pulse count", p, 3);
    check("R8 phase widths", bad, 0);
    wait_for(1'b0, n);
    check("R9 rearm into bus free", n, SHT*DIV);
  endtask

  initial begin
    t_reset();
    t_short_free();
    t_long_free();
    t_activity();
    t_full_recovery();
    t_disable();
    t_early_exit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule